// File: doc/BRIEF.md
# Segment Power-Gating Mode Controller

This block drives the leakage-control signals for every 6-bit segment of a ternary match array. Each segment has a pair of storage-cell supply controls (`ctrl1`, `ctrl2`) that pick full-speed, data-holding or fully cut-off operation. It also has four mask-cell switch enables (`p1_en`, `p2_en`, `n1_en`, `n2_en`). These hold the stored mask value and open the supply path that the value does not need. The choice for each segment comes from two of its stored mask bits, the top one and the bottom one. Both at 1 means the whole segment is don't-care, and its storage data then has no meaning.

A system-level state machine has the states ON, SLEEP and WAKE. The transitions are: ON→SLEEP on `sleep_req`, SLEEP→WAKE on `wake_req`, and WAKE→ON after `WAKE_CYCLES` edges. Each segment has its own state machine with the states ACTIVE, RETAIN and CUTOFF. On sleep entry a segment goes ACTIVE→RETAIN, or ACTIVE→CUTOFF if its top mask bit is 1. While asleep it goes RETAIN→CUTOFF if its top mask bit becomes 1. On wake it goes RETAIN/CUTOFF→ACTIVE. CUTOFF never moves to RETAIN directly. `ready` tells the search logic when the array may be used again.

Top module: `pg_mode_ctrl`

## Requirements
- R1: After reset every segment shows ctrl1=1, ctrl2=1, all four switch enables are 1, and ready is 1.
- R2: With ready=1, sleep_req sampled at a rising edge makes ready 0 at that edge. Every segment whose top mask bit is 0 then shows ctrl1=1, ctrl2=0 (retention).
- R3: A segment whose top mask bit is 1 at the sleep-entry edge shows ctrl1=0, ctrl2=0 (cut-off).
- R4: While asleep, a segment whose top and bottom mask bits were both 1 at the previous edge shows p1_en=1, n2_en=1, p2_en=0, n1_en=0.
- R5: While asleep, a segment whose top and bottom mask bits were both 0 at the previous edge shows p2_en=1, n1_en=1, p1_en=0, n2_en=0.
- R6: While asleep, a segment with unequal top and bottom mask bits keeps all four enables at 1.
- R7: wake_req sampled while asleep returns every segment to ctrl1=1, ctrl2=1 and all enables to 1 at that edge, with ready still 0.
- R8: ready rises exactly WAKE_CYCLES rising edges after the wake edge. sleep_req has no effect while ready is 0 during wake-up.
- R9: A retention segment whose top mask bit becomes 1 during sleep moves to cut-off at the next edge. A cut-off segment stays cut-off until wake, even if its top mask bit returns to 0. The code ctrl1=1, ctrl2=0 never directly follows ctrl1=0, ctrl2=0.
- R10: wake_req while in the ON state changes no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_req | input | 1 | Request to enter standby |
| wake_req | input | 1 | Request to leave standby |
| mask_msb | input | NUM_SEG | Top mask bit of each segment |
| mask_lsb | input | NUM_SEG | Bottom mask bit of each segment |
| ctrl1 | output | NUM_SEG | Storage supply control 1 per segment |
| ctrl2 | output | NUM_SEG | Storage supply control 2 per segment |
| p1_en | output | NUM_SEG | Mask-cell switch P1 enable |
| p2_en | output | NUM_SEG | Mask-cell switch P2 enable |
| n1_en | output | NUM_SEG | Mask-cell switch N1 enable |
| n2_en | output | NUM_SEG | Mask-cell switch N2 enable |
| ready | output | 1 | Array usable for search |

## Verification
Every mode and switch output is registered. A request or mask value present at a rising edge therefore shows on the outputs from that edge on. The bench drives inputs just after a falling edge and compares all outputs at the next falling edge. `ready` is due WAKE_CYCLES edges after the wake edge, and the bench model counts those edges before expecting it high. Mask changes during sleep are checked one edge later in the same way.

// File: rtl/pg_pkg.sv
package pg_pkg;

    typedef enum logic [1:0] {
        SYS_ON    = 2'd0,
        SYS_SLEEP = 2'd1,
        SYS_WAKE  = 2'd2
    } sys_state_e;

    typedef enum logic [1:0] {
        SEG_ACTIVE = 2'd0,
        SEG_RETAIN = 2'd1,
        SEG_CUTOFF = 2'd2
    } seg_mode_e;

    typedef struct packed {
        logic p1;
        logic p2;
        logic n1;
        logic n2;
    } sw_en_t;

    localparam sw_en_t SW_ALL_ON = '{p1: 1'b1, p2: 1'b1, n1: 1'b1, n2: 1'b1};

    // Switch set for a sleeping segment, chosen from its edge mask bits.
    function automatic sw_en_t mask_switches(input logic top, input logic bot);
        sw_en_t s;
        if (top && bot)
            s = '{p1: 1'b1, p2: 1'b0, n1: 1'b0, n2: 1'b1};
        else if (!top && !bot)
            s = '{p1: 1'b0, p2: 1'b1, n1: 1'b1, n2: 1'b0};
        else
            s = SW_ALL_ON;
        return s;
    endfunction

endpackage

// File: rtl/pg_wake_seq.sv
module pg_wake_seq
    import pg_pkg::*;
#(
    parameter int WAKE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic wake_req,
    output logic sleep_enter,
    output logic sleep_hold,
    output logic wake_start,
    output logic ready
);

    localparam int CNT_W = (WAKE_CYCLES < 2) ? 1 : $clog2(WAKE_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAKE_CYCLES - 1);

    sys_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              ready_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SYS_ON;
            cnt_q   <= '0;
            ready_q <= 1'b1;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            ready_q <= (state_d == SYS_ON);
        end
    end

    // Next state and outputs
    always_comb begin
        state_d     = state_q;
        cnt_d       = cnt_q;
        sleep_enter = 1'b0;
        sleep_hold  = 1'b0;
        wake_start  = 1'b0;
        unique case (state_q)
            SYS_ON: begin
                if (sleep_req) begin
                    state_d     = SYS_SLEEP;
                    sleep_enter = 1'b1;
                end
            end
            SYS_SLEEP: begin
                if (wake_req) begin
                    state_d    = SYS_WAKE;
                    cnt_d      = '0;
                    wake_start = 1'b1;
                end else begin
                    sleep_hold = 1'b1;
                end
            end
            SYS_WAKE: begin
                if (cnt_q == CNT_LAST) begin
                    state_d = SYS_ON;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = SYS_ON;
                cnt_d   = '0;
            end
        endcase
    end

    assign ready = ready_q;

endmodule

// File: rtl/pg_seg_ctrl.sv
module pg_seg_ctrl
    import pg_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sleep_enter,
    input  logic   sleep_hold,
    input  logic   wake_start,
    input  logic   mask_top,
    input  logic   mask_bot,
    output logic   ctrl1,
    output logic   ctrl2,
    output sw_en_t sw_en
);

    seg_mode_e mode_q, mode_d;
    sw_en_t    sw_q, sw_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= SEG_ACTIVE;
            sw_q   <= SW_ALL_ON;
        end else begin
            mode_q <= mode_d;
            sw_q   <= sw_d;
        end
    end

    // Next mode and switch selection
    always_comb begin
        mode_d = mode_q;
        sw_d   = SW_ALL_ON;
        unique case (mode_q)
            SEG_ACTIVE: begin
                if (sleep_enter) begin
                    mode_d = mask_top ? SEG_CUTOFF : SEG_RETAIN;
                    sw_d   = mask_switches(mask_top, mask_bot);
                end
            end
            SEG_RETAIN: begin
                if (wake_start) begin
                    mode_d = SEG_ACTIVE;
                end else if (sleep_hold) begin
                    if (mask_top)
                        mode_d = SEG_CUTOFF;
                    sw_d = mask_switches(mask_top, mask_bot);
                end
            end
            SEG_CUTOFF: begin
                if (wake_start) begin
                    mode_d = SEG_ACTIVE;
                end else if (sleep_hold) begin
                    sw_d = mask_switches(mask_top, mask_bot);
                end
            end
            default: begin
                mode_d = SEG_ACTIVE;
            end
        endcase
    end

    // Output decode from registered mode
    always_comb begin
        unique case (mode_q)
            SEG_ACTIVE: begin ctrl1 = 1'b1; ctrl2 = 1'b1; end
            SEG_RETAIN: begin ctrl1 = 1'b1; ctrl2 = 1'b0; end
            SEG_CUTOFF: begin ctrl1 = 1'b0; ctrl2 = 1'b0; end
            default:    begin ctrl1 = 1'b1; ctrl2 = 1'b1; end
        endcase
        sw_en = sw_q;
    end

endmodule

// File: rtl/pg_mode_ctrl.sv
module pg_mode_ctrl
    import pg_pkg::*;
#(
    parameter int NUM_SEG     = 24,
    parameter int WAKE_CYCLES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sleep_req,
    input  logic               wake_req,
    input  logic [NUM_SEG-1:0] mask_msb,
    input  logic [NUM_SEG-1:0] mask_lsb,
    output logic [NUM_SEG-1:0] ctrl1,
    output logic [NUM_SEG-1:0] ctrl2,
    output logic [NUM_SEG-1:0] p1_en,
    output logic [NUM_SEG-1:0] p2_en,
    output logic [NUM_SEG-1:0] n1_en,
    output logic [NUM_SEG-1:0] n2_en,
    output logic               ready
);

    logic sleep_enter;
    logic sleep_hold;
    logic wake_start;

    pg_wake_seq #(
        .WAKE_CYCLES (WAKE_CYCLES)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_req   (sleep_req),
        .wake_req    (wake_req),
        .sleep_enter (sleep_enter),
        .sleep_hold  (sleep_hold),
        .wake_start  (wake_start),
        .ready       (ready)
    );

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        sw_en_t sw;
        pg_seg_ctrl u_seg (
            .clk         (clk),
            .rst_n       (rst_n),
            .sleep_enter (sleep_enter),
            .sleep_hold  (sleep_hold),
            .wake_start  (wake_start),
            .mask_top    (mask_msb[g]),
            .mask_bot    (mask_lsb[g]),
            .ctrl1       (ctrl1[g]),
            .ctrl2       (ctrl2[g]),
            .sw_en       (sw)
        );
        assign p1_en[g] = sw.p1;
        assign p2_en[g] = sw.p2;
        assign n1_en[g] = sw.n1;
        assign n2_en[g] = sw.n2;
    end

endmodule

// File: rtl/pg_mode_ctrl_chk.sv
module pg_mode_ctrl_chk #(
    parameter int NUM_SEG = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sleep_req,
    input logic               wake_req,
    input logic [NUM_SEG-1:0] ctrl1,
    input logic [NUM_SEG-1:0] ctrl2,
    input logic [NUM_SEG-1:0] p1_en,
    input logic [NUM_SEG-1:0] p2_en,
    input logic [NUM_SEG-1:0] n1_en,
    input logic [NUM_SEG-1:0] n2_en,
    input logic               ready
);

    // R2: accepted sleep request drops ready and leaves no segment at full power
    assert_sleep_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && sleep_req) |=> (!ready && (ctrl2 == '0)));

    // R7: wake from sleep restores every segment and every switch
    assert_wake_restore_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && (ctrl2 == '0) && wake_req) |=>
        (!ready && (&ctrl1) && (&ctrl2) && (&p1_en) && (&p2_en) && (&n1_en) && (&n2_en)));

    // R8: ready only while the whole array is at full power
    assert_ready_full_power_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> ((&ctrl1) && (&ctrl2) && (&p1_en) && (&p2_en) && (&n1_en) && (&n2_en)));

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_chk
        // R9: cut-off never steps straight into retention
        assert_no_off_to_ret_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (!ctrl1[g] && !ctrl2[g]) |=> !(ctrl1[g] && !ctrl2[g]));

        // R2: the unused code ctrl1=0, ctrl2=1 never appears
        assert_ctrl_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
            ctrl2[g] |-> ctrl1[g]);

        // R4: while sleeping the switches are all on or a complementary pair
        assert_switch_pairing_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !ctrl2[g] |-> ((p1_en[g] == n2_en[g]) && (p2_en[g] == n1_en[g]) &&
                           (p1_en[g] || p2_en[g])));
    end

endmodule

bind pg_mode_ctrl pg_mode_ctrl_chk #(
    .NUM_SEG (NUM_SEG)
) u_pg_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_req (sleep_req),
    .wake_req  (wake_req),
    .ctrl1     (ctrl1),
    .ctrl2     (ctrl2),
    .p1_en     (p1_en),
    .p2_en     (p2_en),
    .n1_en     (n1_en),
    .n2_en     (n2_en),
    .ready     (ready)
);

// File: tb/pg_mode_ctrl_bench.sv
module pg_mode_ctrl_bench;

    localparam int  NSEG     = 8;
    localparam int  WAKE     = 5;
    localparam time CLK_HALF = 5ns;
    localparam int  MODE_ACT = 0;
    localparam int  MODE_RET = 1;
    localparam int  MODE_OFF = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            sleep_req = 1'b0;
    logic            wake_req = 1'b0;
    logic [NSEG-1:0] mask_msb = '0;
    logic [NSEG-1:0] mask_lsb = '0;
    logic [NSEG-1:0] ctrl1, ctrl2, p1_en, p2_en, n1_en, n2_en;
    logic            ready;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Reference state built from the requirements
    int         m_phase;   // 0 on, 1 sleep, 2 wake
    int         m_cnt;
    bit         m_ready;
    int         m_mode [NSEG];
    logic [3:0] m_sw   [NSEG];   // {p1,p2,n1,n2}

    always #(CLK_HALF) clk = ~clk;

    pg_mode_ctrl #(
        .NUM_SEG     (NSEG),
        .WAKE_CYCLES (WAKE)
    ) u_pg_mode_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_req (sleep_req),
        .wake_req  (wake_req),
        .mask_msb  (mask_msb),
        .mask_lsb  (mask_lsb),
        .ctrl1     (ctrl1),
        .ctrl2     (ctrl2),
        .p1_en     (p1_en),
        .p2_en     (p2_en),
        .n1_en     (n1_en),
        .n2_en     (n2_en),
        .ready     (ready)
    );

    function automatic logic [3:0] sw_expect(input logic top, input logic bot);
        if (top && bot)   return 4'b1001;   // R4
        if (!top && !bot) return 4'b0110;   // R5
        return 4'b1111;                     // R6
    endfunction

    task automatic cmp_vec(input string tag, input string what,
                           input logic [NSEG-1:0] act, input logic [NSEG-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        logic [NSEG-1:0] e1, e2, ep1, ep2, en1, en2;
        for (int i = 0; i < NSEG; i++) begin
            e1[i]  = (m_mode[i] != MODE_OFF);
            e2[i]  = (m_mode[i] == MODE_ACT);
            ep1[i] = m_sw[i][3];
            ep2[i] = m_sw[i][2];
            en1[i] = m_sw[i][1];
            en2[i] = m_sw[i][0];
        end
        cmp_vec(tag, "ctrl1", ctrl1, e1);
        cmp_vec(tag, "ctrl2", ctrl2, e2);
        cmp_vec(tag, "p1_en", p1_en, ep1);
        cmp_vec(tag, "p2_en", p2_en, ep2);
        cmp_vec(tag, "n1_en", n1_en, en1);
        cmp_vec(tag, "n2_en", n2_en, en2);
        checks++;
        if (ready !== m_ready) begin
            errors++;
            $display("FAIL %s ready actual=%b expected=%b", tag, ready, m_ready);
        end
    endtask

    task automatic model_reset();
        m_phase = 0;
        m_cnt   = 0;
        m_ready = 1'b1;
        for (int i = 0; i < NSEG; i++) begin
            m_mode[i] = MODE_ACT;
            m_sw[i]   = 4'b1111;
        end
    endtask

    // Apply inputs, advance one edge, update the reference, compare.
    task automatic cycle(input logic s, input logic w,
                         input logic [NSEG-1:0] top, input logic [NSEG-1:0] bot,
                         input string tag_in);
        string tag;
        sleep_req = s;
        wake_req  = w;
        mask_msb  = top;
        mask_lsb  = bot;
        case (m_phase)
            0: begin
                if (s) begin
                    tag     = "R2";
                    m_phase = 1;
                    m_ready = 1'b0;
                    for (int i = 0; i < NSEG; i++) begin
                        m_mode[i] = top[i] ? MODE_OFF : MODE_RET;
                        m_sw[i]   = sw_expect(top[i], bot[i]);
                    end
                end else begin
                    tag = "R10";
                end
            end
            1: begin
                if (w) begin
                    tag     = "R7";
                    m_phase = 2;
                    m_cnt   = 0;
                    for (int i = 0; i < NSEG; i++) begin
                        m_mode[i] = MODE_ACT;
                        m_sw[i]   = 4'b1111;
                    end
                end else begin
                    tag = "R9";
                    for (int i = 0; i < NSEG; i++) begin
                        if (m_mode[i] == MODE_RET && top[i]) m_mode[i] = MODE_OFF;
                        m_sw[i] = sw_expect(top[i], bot[i]);
                    end
                end
            end
            default: begin
                tag = "R8";
                m_cnt++;
                if (m_cnt == WAKE) begin
                    m_phase = 0;
                    m_ready = 1'b1;
                end
            end
        endcase
        if (tag_in != "") tag = tag_in;
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [NSEG-1:0] top, bot;
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(negedge clk);
        compare_all("R1");           // R1 in reset
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R1");           // R1 after release

        // R10: wake while on is ignored
        cycle(1'b0, 1'b1, '0, '0, "R10");
        cycle(1'b0, 1'b1, '1, '1, "R10");

        // Segment patterns: 0,1 all-ones; 2,3 all-zeros; 4 top only; 5 bottom only; 6,7 zeros
        top = 8'b0001_0011;
        bot = 8'b0010_0011;
        cycle(1'b1, 1'b0, top, bot, "R3");   // R3 cut-off for top=1, R2 retention else
        cycle(1'b0, 1'b0, top, bot, "R4");   // R4 / R5 / R6 switch sets
        cycle(1'b0, 1'b0, top, bot, "R6");
        // R9: segment 2 (retention) sees top rise; segment 0 (cut-off) sees top fall
        top = 8'b0001_0110;
        cycle(1'b0, 1'b0, top, bot, "R9");
        cycle(1'b0, 1'b0, top, bot, "R5");
        // R7 wake, then R8 with sleep_req held during wake-up
        cycle(1'b0, 1'b1, top, bot, "R7");
        for (int k = 0; k < WAKE; k++) cycle(1'b1, 1'b0, top, bot, "R8");
        cycle(1'b0, 1'b0, top, bot, "R8");

        // Constrained random traffic
        for (int k = 0; k < 3000; k++) begin
            if (($urandom % 6) == 0) top = NSEG'($urandom);
            if (($urandom % 6) == 0) bot = NSEG'($urandom);
            cycle((($urandom % 5) == 0), (($urandom % 7) == 0), top, bot, "");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule